// File: doc/BRIEF.md
# Operate and Branch-Test Execute Stage

This block is the execute stage for the arithmetic, logic and shift instructions of a 16-bit load/store processor. Each cycle it decodes a 16-bit instruction word together with the two register operands that the register file supplies. It then produces the value to write back, the destination register index and a write strobe. For the register file read ports it also passes on the two source indices that the instruction names.

The block owns the processor's three condition flags (negative, zero, positive). When a flag-setting instruction retires, the flags are updated from the written value. A restore port can overwrite them from a saved status word, and this port takes priority over result-based updates. For a conditional-branch instruction, the block reports whether the branch is taken by testing the flags the instruction selects against the current flag state. Address arithmetic, memory traffic and fetch are handled outside this block.

Top module: `opx_exec_unit`

## Requirements
- R1: The opcode is `instr[15:12]`. 0001 selects add, 0101 selects AND, 1001 selects complement and 1101 selects shift. `rf_we` is high only when one of these four opcodes is present and `step_en` is high. For every other opcode, `result` is zero. `dest_idx` = `instr[11:9]`, `src_a_idx` = `instr[8:6]` and `src_b_idx` = `instr[2:0]`.
- R2: For add with `instr[5]`=0, `result` = `opnd_a` + `opnd_b` modulo 2^16.
- R3: For add and AND with `instr[5]`=1, the second operand is `instr[4:0]` sign-extended to 16 bits, and `opnd_b` is ignored.
- R4: For AND with `instr[5]`=0, `result` = `opnd_a` & `opnd_b`.
- R5: Complement gives `result` = ~`opnd_a`.
- R6: For shift with `instr[4]`=0, `opnd_a` is shifted left by `instr[3:0]` (0 to 15) places, with zeros shifted in and the bits shifted out dropped.
- R7: For shift with `instr[4]`=1 and `instr[5]`=0, `opnd_a` is shifted right by `instr[3:0]` places with zero fill.
- R8: For shift with `instr[4]`=1 and `instr[5]`=1, `opnd_a` is shifted right by `instr[3:0]` places, and the vacated positions are filled with the original `opnd_a[15]`.
- R9: On a rising clock edge where `rf_we` is high, `flags_nzp` ({N,Z,P} at bits 2,1,0) becomes one-hot from `result` taken as two's complement: 100 if negative, 010 if zero, 001 if positive.
- R10: The flags keep their value on any edge where neither `rf_we` nor `flag_load` is high.
- R11: While `rst_n` is low, the flags are 010.
- R12: On an edge with `flag_load` high, `flags_nzp` takes `flag_load_val`, whatever the instruction and `step_en`.
- R13: With opcode 0000, `br_taken` = OR of (`instr[11:9]` AND `flags_nzp`), so 111 always branches and 000 never does. For any other opcode, `br_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word |
| opnd_a | input | 16 | First source register value |
| opnd_b | input | 16 | Second source register value |
| step_en | input | 1 | Instruction retires this cycle |
| flag_load | input | 1 | Restore flags from `flag_load_val` |
| flag_load_val | input | 3 | Restored {N,Z,P} |
| result | output | 16 | Write-back value |
| dest_idx | output | 3 | Destination register index |
| src_a_idx | output | 3 | First source register index |
| src_b_idx | output | 3 | Second source register index |
| rf_we | output | 1 | Register file write strobe |
| flags_nzp | output | 3 | Current {N,Z,P} flags |
| br_taken | output | 1 | Conditional branch taken |

## Verification
The hardest case to reach from the ports is a collision on the flag register: a flag restore lands on the same edge as a retiring flag-setting instruction. The stimulus drives an add whose result would set Z together with a restore value of P, then checks that P wins. It then issues a branch that tests only P, which exposes the stored state through the normal branch output. The shift amount extremes 0 and 15 are also covered, as are arithmetic right shifts of both signs and add overflow into the sign bit.

// File: rtl/opx_pkg.sv
package opx_pkg;
   localparam logic [3:0] OPC_BR  = 4'b0000;
   localparam logic [3:0] OPC_ADD = 4'b0001;
   localparam logic [3:0] OPC_AND = 4'b0101;
   localparam logic [3:0] OPC_NOT = 4'b1001;
   localparam logic [3:0] OPC_SHF = 4'b1101;

   localparam logic [2:0] FLAGS_RESET = 3'b010;

   typedef enum logic [2:0] {
      K_NONE, K_ADD, K_AND, K_NOT, K_SHF
   } op_kind_e;

   function automatic op_kind_e classify(input logic [3:0] opc);
      case (opc)
         OPC_ADD: return K_ADD;
         OPC_AND: return K_AND;
         OPC_NOT: return K_NOT;
         OPC_SHF: return K_SHF;
         default: return K_NONE;
      endcase
   endfunction
endpackage

// File: rtl/opx_shifter.sv
module opx_shifter #(
   parameter int DATA_W       = 16,
   parameter int SHAMT_W      = 4,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [DATA_W-1:0]  din,
   input  logic [SHAMT_W-1:0] amt,
   input  logic               right,
   input  logic               arith,
   output logic [DATA_W-1:0]  dout
);
   initial begin
      assert (DATA_W == (1 << SHAMT_W))
         else $error("opx_shifter: DATA_W must equal 2**SHAMT_W");
   end

   logic fill;
   assign fill = right & arith & din[DATA_W-1];

   generate
      if (SHIFT_STAGED) begin : g_staged
         logic [SHAMT_W:0][DATA_W-1:0] st;
         assign st[0] = din;
         for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
            localparam int S = 1 << k;
            logic [DATA_W-1:0] moved;
            assign moved = right ? {{S{fill}}, st[k][DATA_W-1:S]}
                                 : {st[k][DATA_W-1-S:0], {S{1'b0}}};
            assign st[k+1] = amt[k] ? moved : st[k];
         end
         assign dout = st[SHAMT_W];
      end else begin : g_direct
         logic [DATA_W-1:0] rs_l, rs_a, ls;
         assign ls   = din << amt;
         assign rs_l = din >> amt;
         assign rs_a = DATA_W'($signed(din) >>> amt);
         assign dout = right ? (arith ? rs_a : rs_l) : ls;
      end
   endgenerate
endmodule

// File: rtl/opx_alu.sv
module opx_alu
   import opx_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int SHAMT_W      = 4,
   parameter int IMM_W        = 5,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic [3:0]        opc,
   input  logic [5:0]        low,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              is_op
);
   localparam int EXT_W = DATA_W - IMM_W;

   initial begin
      assert (IMM_W < DATA_W && IMM_W <= 5)
         else $error("opx_alu: IMM_W out of range");
   end

   op_kind_e          kind;
   logic [DATA_W-1:0] imm_ext, op2, shf_out;

   assign kind    = classify(opc);
   assign is_op   = (kind != K_NONE);
   assign imm_ext = {{EXT_W{low[IMM_W-1]}}, low[IMM_W-1:0]};
   assign op2     = low[5] ? imm_ext : b;

   opx_shifter #(
      .DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .SHIFT_STAGED(SHIFT_STAGED)
   ) u_shf (
      .din(a), .amt(low[SHAMT_W-1:0]), .right(low[4]), .arith(low[5]),
      .dout(shf_out)
   );

   always_comb begin
      case (kind)
         K_ADD:   res = a + op2;
         K_AND:   res = a & op2;
         K_NOT:   res = ~a;
         K_SHF:   res = shf_out;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/opx_flag_reg.sv
module opx_flag_reg
   import opx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [DATA_W-1:0] res,
   input  logic              load_en,
   input  logic [2:0]        load_val,
   output logic [2:0]        flags_q
);
   logic neg, zer;
   assign neg = res[DATA_W-1];
   assign zer = (res == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)       flags_q <= FLAGS_RESET;
      else if (load_en) flags_q <= load_val;
      else if (set_en)  flags_q <= {neg, zer, ~neg & ~zer};
   end

   assert_set_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_en && !load_en |=> $countones(flags_q) == 1);
   assert_zero_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_en && !load_en |=> flags_q[1] == ($past(res) == '0));
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en && !load_en |=> $stable(flags_q));
   assert_restore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> flags_q == $past(load_val));
endmodule

// File: rtl/opx_exec_unit.sv
module opx_exec_unit
   import opx_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int SHAMT_W      = 4,
   parameter int IMM_W        = 5,
   parameter int IDX_W        = 3,
   parameter bit SHIFT_STAGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              step_en,
   input  logic              flag_load,
   input  logic [2:0]        flag_load_val,
   output logic [DATA_W-1:0] result,
   output logic [IDX_W-1:0]  dest_idx,
   output logic [IDX_W-1:0]  src_a_idx,
   output logic [IDX_W-1:0]  src_b_idx,
   output logic              rf_we,
   output logic [2:0]        flags_nzp,
   output logic              br_taken
);
   initial begin
      assert (IDX_W == 3) else $error("opx_exec_unit: IDX_W must be 3");
   end

   logic [3:0] opc;
   logic       is_op;

   assign opc       = instr[15:12];
   assign dest_idx  = instr[11:9];
   assign src_a_idx = instr[8:6];
   assign src_b_idx = instr[2:0];

   opx_alu #(
      .DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .IMM_W(IMM_W),
      .SHIFT_STAGED(SHIFT_STAGED)
   ) u_alu (
      .opc(opc), .low(instr[5:0]), .a(opnd_a), .b(opnd_b),
      .res(result), .is_op(is_op)
   );

   assign rf_we = is_op & step_en;

   opx_flag_reg #(.DATA_W(DATA_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_en(rf_we), .res(result),
      .load_en(flag_load), .load_val(flag_load_val), .flags_q(flags_nzp)
   );

   assign br_taken = (opc == OPC_BR) & |(instr[11:9] & flags_nzp);

   assert_branch_opcode_R13: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> opc == OPC_BR);
   assert_write_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> step_en);
endmodule

// File: tb/opx_exec_unit_test.sv
module opx_exec_unit_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] instr, opnd_a, opnd_b, result;
   logic        step_en, flag_load, rf_we, br_taken;
   logic [2:0]  flag_load_val, dest_idx, src_a_idx, src_b_idx, flags_nzp;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   opx_exec_unit uut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .opnd_a(opnd_a),
      .opnd_b(opnd_b), .step_en(step_en), .flag_load(flag_load),
      .flag_load_val(flag_load_val), .result(result), .dest_idx(dest_idx),
      .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .rf_we(rf_we),
      .flags_nzp(flags_nzp), .br_taken(br_taken)
   );

   typedef struct packed {
      logic [15:0] ins, a, b, res;
      logic [2:0]  f;
   } vec_t;

   localparam vec_t VEC [0:11] = '{
      '{16'h14C4, 16'h1234, 16'h0101, 16'h1335, 3'b001},
      '{16'h14FF, 16'h0001, 16'h5555, 16'h0000, 3'b010},
      '{16'h14C4, 16'h7FFF, 16'h0001, 16'h8000, 3'b100},
      '{16'h54C4, 16'hF0F0, 16'h0FF0, 16'h00F0, 3'b001},
      '{16'h54F0, 16'h8005, 16'h0000, 16'h8000, 3'b100},
      '{16'h94FF, 16'hFFFF, 16'h1234, 16'h0000, 3'b010},
      '{16'hD4C3, 16'h1FFF, 16'h0000, 16'hFFF8, 3'b100},
      '{16'hD4D7, 16'hFFFF, 16'h0000, 16'h01FF, 3'b001},
      '{16'hD4F7, 16'h8000, 16'h0000, 16'hFF00, 3'b100},
      '{16'hD4FF, 16'h7FFF, 16'h0000, 16'h0000, 3'b010},
      '{16'hD4C0, 16'h4321, 16'h0000, 16'h4321, 3'b001},
      '{16'hD4CF, 16'h0003, 16'h0000, 16'h8000, 3'b100}
   };

   function automatic string vtag(int i);
      case (i)
         0, 2:     return "R2";
         1, 4:     return "R3";
         3:        return "R4";
         5:        return "R5";
         7:        return "R7";
         8, 9:     return "R8";
         default:  return "R6";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic [15:0] i, logic [15:0] a, logic [15:0] b, logic en);
      instr = i; opnd_a = a; opnd_b = b; step_en = en;
   endtask

   initial begin
      rst_n = 1'b0; flag_load = 1'b0; flag_load_val = 3'b000;
      drive(16'h0000, 16'h0, 16'h0, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R11 reset flags", 32'(flags_nzp), 32'(3'b010));
      rst_n = 1'b1;
      drive(16'h0E00, 16'h0, 16'h0, 1'b0); #2;
      chk("R13 nzp=111 after reset", 32'(br_taken), 32'd1);
      drive(16'h0800, 16'h0, 16'h0, 1'b0); #2;
      chk("R13 n-only with Z set", 32'(br_taken), 32'd0);

      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         drive(VEC[i].ins, VEC[i].a, VEC[i].b, 1'b1); #2;
         chk(vtag(i), 32'(result), 32'(VEC[i].res));
         chk("R1 write strobe", 32'(rf_we), 32'd1);
         chk("R1 indices", {23'd0, dest_idx, src_a_idx, src_b_idx},
             {23'd0, 3'd2, 3'd3, VEC[i].ins[2:0]});
         @(negedge clk);
         step_en = 1'b0; #1;
         chk("R9 flags", 32'(flags_nzp), 32'(VEC[i].f));
      end

      drive(16'h0800, 16'h0, 16'h0, 1'b0); #2;
      chk("R13 n-only with N set", 32'(br_taken), 32'd1);
      drive(16'h0200, 16'h0, 16'h0, 1'b0); #2;
      chk("R13 p-only with N set", 32'(br_taken), 32'd0);
      drive(16'h0000, 16'h0, 16'h0, 1'b0); #2;
      chk("R13 nzp=000", 32'(br_taken), 32'd0);
      drive(16'h1E00, 16'h0, 16'h0, 1'b0); #2;
      chk("R13 non-branch opcode", 32'(br_taken), 32'd0);

      @(negedge clk);
      drive(16'h14C4, 16'h0001, 16'h0001, 1'b0); #2;
      chk("R1 no strobe without step_en", 32'(rf_we), 32'd0);
      @(negedge clk); #1;
      chk("R10 flags held, step_en low", 32'(flags_nzp), 32'(3'b100));

      drive(16'h6000, 16'h0005, 16'h0005, 1'b1); #2;
      chk("R1 other opcode result", 32'(result), 32'd0);
      chk("R1 other opcode strobe", 32'(rf_we), 32'd0);
      @(negedge clk); #1;
      chk("R10 flags held, other opcode", 32'(flags_nzp), 32'(3'b100));

      drive(16'h14FF, 16'h0001, 16'h0000, 1'b1);
      flag_load = 1'b1; flag_load_val = 3'b001;
      @(negedge clk);
      flag_load = 1'b0; step_en = 1'b0; #1;
      chk("R12 restore beats result", 32'(flags_nzp), 32'(3'b001));
      drive(16'h0200, 16'h0, 16'h0, 1'b0); #2;
      chk("R13 p-only after restore", 32'(br_taken), 32'd1);

      flag_load = 1'b1; flag_load_val = 3'b010;
      @(negedge clk);
      flag_load = 1'b0; #1;
      chk("R12 restore with step_en low", 32'(flags_nzp), 32'(3'b010));

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule